// File: doc/BRIEF.md
# Four-Channel Step Pulse Generator

This block drives four stepper-style axes. Each axis receives a signed rate command and produces two lines: a step line that pulses and a direction line. The block does not make its own timebase. It advances only on a one-cycle enable strobe, `pfm_tick`, which an external divider produces. The pulse rate is proportional to the command magnitude. A 16-bit phase accumulator per channel adds the clamped magnitude on every tick. A carry out of the accumulator requests a step pulse.

Each channel has a two-state machine. In state `ST_IDLE` the step line is low and the direction line follows the command sign. Transition START goes to `ST_HIGH` when a carry arrives and the width setting is non-zero. Transition SKIP stays in `ST_IDLE` when a carry arrives with width zero. In `ST_HIGH` the step line is high. Transition HOLD stays there while the per-pulse tick counter is non-zero. Transition END returns to `ST_IDLE` on the tick where the counter has reached zero. One 8-bit width register is shared by all four channels. Every pulse lasts that many ticks.

Top module: `pfm_stepgen`

## Requirements
- R1: Starting from reset with command magnitude M ≤ 16384 and no dropped carries, exactly floor(N·M/65536) step pulses begin within N ticks.
- R2: A command magnitude above 16384 is treated as 16384. Channel i's command occupies `freq_cmd[16*i +: 16]`. This caps the rate at one pulse per four ticks, and the most negative value -32768 behaves like 16384.
- R3: A step pulse rises and falls only on clock edges where `pfm_tick` was high. It stays high for exactly W ticks, where W is the width setting at the pulse's start.
- R4: The shared width register resets to 15. It loads `width_din` on any cycle with `width_wr` high, and the value applies to all four channels.
- R5: A width write during a pulse does not change that pulse. It applies only from the next pulse onward.
- R6: With width 0 no pulse is produced, but the accumulators keep adding. After a non-zero width is written, the pulse count continues from the accumulated phase.
- R7: The direction output is 1 for a negative command and 0 otherwise. It is loaded one clock after the command while no pulse is high, and it holds while a pulse is high.
- R8: A carry that arrives while a pulse is still high, including on its final tick, is discarded and not deferred.
- R9: Reset clears every accumulator and drives all step and direction outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pfm_tick | input | 1 | Timebase enable strobe, one clock wide |
| width_wr | input | 1 | Load strobe for the shared width register |
| width_din | input | 8 | Pulse width in ticks (0 disables pulses) |
| freq_cmd | input | 64 | Four signed 16-bit rate commands, channel 0 in the low bits |
| step_out | output | 4 | Step pulse per channel |
| dir_out | output | 4 | Direction per channel (1 = negative) |

## Verification
The bench targets the clamp edge with commands of +20000 and -32768. A design that saturated wrongly or mishandled the most negative value would pulse faster than one per four ticks, or at a wrong rate. It measures the high time of the reset-default width and of a width rewritten mid-pulse. An off-by-one counter would give W±1, and a design that re-read the register would cut the running pulse short. A wide pulse at the maximum rate exposes a design that queues carries instead of dropping them, because the pulse count would rise. A width-zero phase followed by a restart shows whether the accumulator kept running: a frozen accumulator produces too few pulses afterwards.

// File: rtl/pfm_stepgen_pkg.sv
package pfm_stepgen_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HIGH = 1'b1
    } step_state_e;
endpackage

// File: rtl/stepgen_mag.sv
// Signed command to clamped unsigned magnitude plus sign.
module stepgen_mag #(
    parameter int CMD_W = 16,
    parameter int ACC_W = 16
) (
    input  logic [CMD_W-1:0] cmd,
    output logic [ACC_W-2:0] mag,
    output logic             neg
);
    localparam int unsigned        CEIL   = 1 << (ACC_W - 2);
    localparam logic [CMD_W-1:0]   CEIL_C = CMD_W'(CEIL);
    localparam logic [ACC_W-2:0]   CEIL_M = (ACC_W-1)'(CEIL);

    logic [CMD_W-1:0] absv;
    logic             over;

    always_comb begin
        neg  = cmd[CMD_W-1];
        absv = neg ? (~cmd + 1'b1) : cmd;
        over = absv > CEIL_C;
        mag  = over ? CEIL_M : absv[ACC_W-2:0];
    end
endmodule

// File: rtl/stepgen_chan.sv
// One channel: phase accumulator plus pulse state machine.
module stepgen_chan
    import pfm_stepgen_pkg::*;
#(
    parameter int ACC_W = 16,
    parameter int WID_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [ACC_W-2:0] mag,
    input  logic             neg,
    input  logic [WID_W-1:0] width,
    output logic             step,
    output logic             dir
);
    step_state_e      state, nstate;
    logic [ACC_W-1:0] acc;
    logic [ACC_W:0]   sum;
    logic             carry;
    logic [WID_W-1:0] cnt;

    always_comb begin
        sum   = {1'b0, acc} + {2'b00, mag};
        carry = sum[ACC_W];
    end

    // next-state logic: START / SKIP / HOLD / END
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE: if (tick && carry && (width != '0)) nstate = ST_HIGH;
            ST_HIGH: if (tick && (cnt == '0))            nstate = ST_IDLE;
            default: nstate = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
            cnt <= '0;
            dir <= 1'b0;
        end else begin
            if (tick) begin
                acc <= sum[ACC_W-1:0];
                if (state == ST_IDLE && nstate == ST_HIGH)
                    cnt <= width - 1'b1;
                else if (state == ST_HIGH && cnt != '0)
                    cnt <= cnt - 1'b1;
            end
            if (state == ST_IDLE)
                dir <= neg;
        end
    end

    // outputs
    always_comb begin
        step = (state == ST_HIGH);
    end
endmodule

// File: rtl/pfm_stepgen.sv
module pfm_stepgen #(
    parameter int NCH     = 4,
    parameter int CMD_W   = 16,
    parameter int ACC_W   = 16,
    parameter int WID_W   = 8,
    parameter int WID_RST = 15
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   pfm_tick,
    input  logic                   width_wr,
    input  logic [WID_W-1:0]       width_din,
    input  logic [NCH*CMD_W-1:0]   freq_cmd,
    output logic [NCH-1:0]         step_out,
    output logic [NCH-1:0]         dir_out
);
    localparam logic [WID_W-1:0] WID_INIT = WID_W'(WID_RST);

    logic [WID_W-1:0] width_q;

    always_ff @(posedge clk) begin
        if (!rst_n)        width_q <= WID_INIT;
        else if (width_wr) width_q <= width_din;
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic [ACC_W-2:0] mag;
        logic             neg;

        stepgen_mag #(.CMD_W(CMD_W), .ACC_W(ACC_W)) mag_i (
            .cmd (freq_cmd[i*CMD_W +: CMD_W]),
            .mag (mag),
            .neg (neg)
        );

        stepgen_chan #(.ACC_W(ACC_W), .WID_W(WID_W)) chan_i (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (pfm_tick),
            .mag   (mag),
            .neg   (neg),
            .width (width_q),
            .step  (step_out[i]),
            .dir   (dir_out[i])
        );
    end
endmodule

// File: rtl/pfm_stepgen_chk.sv
module pfm_stepgen_chk #(
    parameter int NCH     = 4,
    parameter int WID_W   = 8,
    parameter int WID_RST = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pfm_tick,
    input logic [WID_W-1:0] width_q,
    input logic [NCH-1:0]   step_out,
    input logic [NCH-1:0]   dir_out
);
    // R4: width register holds its reset value when reset releases
    p_width_reset_r4: assert property (@(posedge clk)
        $rose(rst_n) |-> (width_q == WID_W'(WID_RST)));

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        p_rise_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(step_out[i]) |-> $past(pfm_tick));

        p_fall_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(step_out[i]) |-> $past(pfm_tick));

        p_dir_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (step_out[i] && $past(step_out[i])) |-> $stable(dir_out[i]));

        p_zero_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(width_q == '0) && !$past(step_out[i])) |-> !step_out[i]);
    end
endmodule

bind pfm_stepgen pfm_stepgen_chk #(.NCH(NCH), .WID_W(WID_W), .WID_RST(WID_RST)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .pfm_tick (pfm_tick),
    .width_q  (width_q),
    .step_out (step_out),
    .dir_out  (dir_out)
);

// File: tb/pfm_stepgen_tb_top.sv
`timescale 1ns/1ps
module pfm_stepgen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pfm_tick = 1'b0;
    logic        width_wr = 1'b0;
    logic [7:0]  width_din = 8'd0;
    logic [63:0] freq_cmd = 64'd0;
    logic [3:0]  step_out;
    logic [3:0]  dir_out;

    int checks = 0;
    int errors = 0;
    int rise_cnt [4];
    logic [3:0] prev_step = 4'b0;
    int hi_ticks = 0;
    int exp_hi [$];
    bit done = 0;

    always #5 clk = ~clk;

    pfm_stepgen dut_i (
        .clk(clk), .rst_n(rst_n), .pfm_tick(pfm_tick),
        .width_wr(width_wr), .width_din(width_din), .freq_cmd(freq_cmd),
        .step_out(step_out), .dir_out(dir_out)
    );

    task automatic check(input bit ok, input string req, input int got, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // monitor: counts rising edges, measures channel 0 high time in ticks
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_step <= 4'b0;
        end else begin
            for (int c = 0; c < 4; c++)
                if (step_out[c] && !prev_step[c]) rise_cnt[c]++;
            if (step_out[0] && !prev_step[0]) hi_ticks = 0;
            if (step_out[0] && pfm_tick) hi_ticks++;
            if (!step_out[0] && prev_step[0] && exp_hi.size() > 0) begin
                int e;
                e = exp_hi.pop_front();
                check(hi_ticks == e, "R3/R5 high time", hi_ticks, e);
            end
            prev_step <= step_out;
        end
    end

    function automatic int exp_mag(input int v);
        int a;
        a = (v < 0) ? -v : v;
        return (a > 16384) ? 16384 : a;
    endfunction

    // pulse count for n ticks from zero phase, carries during a pulse dropped
    function automatic int model_count(input int m, input int w, input int n);
        longint acc = 0;
        int cnt = 0;
        int start = 0;
        bit started = 0;
        for (int t = 1; t <= n; t++) begin
            acc += m;
            if (acc >= 65536) begin
                acc -= 65536;
                if (w > 0 && (!started || t > start + w)) begin
                    cnt++; start = t; started = 1;
                end
            end
        end
        return cnt;
    endfunction

    task automatic set_cmd(input int ch, input int v);
        freq_cmd[ch*16 +: 16] = 16'(v);
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst_n = 0; pfm_tick = 0; width_wr = 0; freq_cmd = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
    endtask

    task automatic write_width(input int w);
        @(posedge clk); #1;
        width_wr = 1; width_din = 8'(w);
        @(posedge clk); #1;
        width_wr = 0;
    endtask

    task automatic clear_counts();
        for (int c = 0; c < 4; c++) rise_cnt[c] = 0;
    endtask

    task automatic run_ticks(input int n, input int gap);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #1 pfm_tick = 1;
            for (int g = 0; g < gap; g++) begin
                @(posedge clk); #1 pfm_tick = 0;
            end
        end
        @(posedge clk); #1 pfm_tick = 0;
        repeat (3) @(posedge clk);
        #1;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int cmds [4];
        int exp_c;
        // R9 reset state
        do_reset();
        @(negedge clk);
        check(step_out == 4'b0, "R9 step after reset", int'(step_out), 0);
        check(dir_out == 4'b0, "R9 dir after reset", int'(dir_out), 0);

        // R4 default width 15, measured with slow ticks (R3)
        set_cmd(0, 5000);
        exp_hi.push_back(15);
        run_ticks(40, 2);
        check(exp_hi.size() == 0, "R4 default-width pulse seen", exp_hi.size(), 0);

        // R1/R2 rates on four channels, width 2
        do_reset();
        write_width(2);
        cmds = '{1000, -3000, 20000, -32768};
        for (int c = 0; c < 4; c++) set_cmd(c, cmds[c]);
        clear_counts();
        run_ticks(2000, 0);
        for (int c = 0; c < 4; c++) begin
            exp_c = model_count(exp_mag(cmds[c]), 2, 2000);
            check(rise_cnt[c] == exp_c, (c >= 2) ? "R2 clamped rate" : "R1 rate", rise_cnt[c], exp_c);
        end
        check(dir_out == 4'b1010, "R7 dir sign", int'(dir_out), 10);

        // R6 width zero keeps accumulating
        do_reset();
        write_width(0);
        cmds = '{7000, 12000, -9000, 16384};
        for (int c = 0; c < 4; c++) set_cmd(c, cmds[c]);
        clear_counts();
        run_ticks(500, 0);
        for (int c = 0; c < 4; c++)
            check(rise_cnt[c] == 0, "R6 no pulse at width 0", rise_cnt[c], 0);
        write_width(3);
        clear_counts();
        run_ticks(700, 0);
        for (int c = 0; c < 4; c++) begin
            int m;
            m = exp_mag(cmds[c]);
            exp_c = (1200 * m) / 65536 - (500 * m) / 65536;
            check(rise_cnt[c] == exp_c, "R6 phase continues", rise_cnt[c], exp_c);
        end

        // R5 width written mid-pulse
        do_reset();
        write_width(20);
        set_cmd(0, 16384);
        exp_hi.push_back(20);
        exp_hi.push_back(3);
        fork
            run_ticks(80, 0);
            begin
                do @(negedge clk); while (!step_out[0]);
                @(posedge clk); #1 width_wr = 1; width_din = 8'd3;
                @(posedge clk); #1 width_wr = 0;
            end
        join
        check(exp_hi.size() == 0, "R5 both pulses measured", exp_hi.size(), 0);

        // R8 carries during a pulse are dropped
        do_reset();
        write_width(10);
        set_cmd(0, 16384);
        clear_counts();
        run_ticks(1000, 0);
        exp_c = model_count(16384, 10, 1000);
        check(rise_cnt[0] == exp_c && exp_c == 84, "R8 dropped carries", rise_cnt[0], 84);

        // R7 direction held during pulse
        do_reset();
        write_width(40);
        set_cmd(0, 16384);
        fork
            run_ticks(200, 0);
            begin
                do @(negedge clk); while (!step_out[0]);
                @(posedge clk); #1 set_cmd(0, -16384);
                repeat (5) @(negedge clk);
                check(dir_out[0] == 1'b0 && step_out[0], "R7 dir held in pulse", int'(dir_out[0]), 0);
                do @(negedge clk); while (step_out[0]);
                @(negedge clk);
                check(dir_out[0] == 1'b1, "R7 dir after pulse", int'(dir_out[0]), 1);
            end
        join

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule